// File: doc/BRIEF.md
# Line-Merging Store Fill Buffer

This block sits between a store pipeline and the next memory level. It keeps a small pool of entries, each one full cache line wide. A cacheable store whose line has no entry takes a free entry and starts a read-for-ownership for that line. Later stores to the same line do not take a new entry. They merge into the existing entry under a per-byte written mask, whether they hit the same bytes, new bytes or overlapping bytes.

When the ownership data returns, it supplies only the bytes that no store has written yet. The finished line then leaves on the write-out port as one transfer with every byte enable set, and the entry frees when that transfer is accepted. Uncacheable stores skip the pool. Each one goes out on the write-out port as a single partial write, but only when no finished line is waiting. If a cacheable store needs an entry and the pool is full, the store is held and a counter records the event once for that request.

Top module: `line_merge_buffer`

## Requirements
- R1: After reset, `fr_valid` and `wo_valid` are 0 and `full_count` is 0.
- R2: A cacheable store (`st_uc`=0) whose line has no entry takes the lowest-numbered free entry. That entry then raises exactly one fill request, with `fr_line` = `st_addr[ADDR_W-1:6]` and `fr_tag` = the entry index. Requests go out in order of entry index.
- R3: A cacheable store to a line that already holds an entry causes no further fill request. This holds for rewrites of the same bytes, for new bytes of the line and for overlapping bytes.
- R4: A fill response (`fp_valid`, `fp_tag`) takes bytes from `fp_data` only where no store has written. Every written byte keeps the value of the latest store to it. Byte k of a line occupies `[8k+7:8k]` on both data buses.
- R5: A filled line is offered on the write-out port with `wo_uc`=0, its line number, all 64 `wo_be` bits set and the merged data. It stays offered until `wo_ready`, and its entry frees on that accepted cycle.
- R6: An uncacheable store creates no entry and no fill request. It appears on the write-out port in the same cycle it is accepted, with `wo_uc`=1, `wo_line` set to its line, `wo_be` equal to `st_be` shifted to its word, and its data at the same byte positions.
- R7: An uncacheable store is not accepted while any filled line is waiting for write-out. The waiting line goes first.
- R8: The pool holds `NUM_ENTRIES` lines. A cacheable store that needs a new entry when none is free sees `st_ready`=0. `full_count` rises by exactly one for each such held request, however many cycles it is held.
- R9: A held store is accepted once an entry has been freed by write-out.
- R10: `st_addr` is a byte address. Bits [5:3] select the 8-byte word in the line and bits [2:0] are ignored. `st_be` bit k enables byte k of `st_data`, which lands on line byte 8*word+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 64 | Store data, one 8-byte word |
| st_be | input | 8 | Store byte enables |
| st_uc | input | 1 | Store is uncacheable |
| fr_valid | output | 1 | Fill request valid |
| fr_ready | input | 1 | Fill request accepted |
| fr_line | output | ADDR_W-6 | Line number to fetch |
| fr_tag | output | TAG_W | Entry index carried by the request |
| fp_valid | input | 1 | Fill response valid |
| fp_tag | input | TAG_W | Entry index of the response |
| fp_data | input | 512 | Returned line data |
| wo_valid | output | 1 | Write-out valid |
| wo_ready | input | 1 | Write-out accepted |
| wo_uc | output | 1 | Write-out is an uncacheable partial write |
| wo_line | output | ADDR_W-6 | Line number written |
| wo_data | output | 512 | Write-out data |
| wo_be | output | 64 | Write-out byte enables |
| full_count | output | CNT_W | Count of store requests that found the pool full |

## Verification
The bench uses the default build: ten entries, 64-byte lines, 8-byte store words and a 32-bit address. With these values, ten line-strided stores fill the pool, so the eleventh stall and the one-count-per-request rule can be reached in a few dozen cycles. The 64-bit byte-enable and 512-bit data paths are checked byte by byte against a model of the merged line built inside the bench.

// File: rtl/lmb_pkg.sv
// Package: shared types for the line merging fill buffer.
// Assumes nothing beyond the parameters of the top module.
package lmb_pkg;

    // Source that owns the write-out port in a given cycle.
    typedef enum logic {
        WO_SRC_LINE  = 1'b0,
        WO_SRC_UNCAC = 1'b1
    } wo_src_e;

endpackage

// File: rtl/lmb_first.sv
// Module: lowest-index picker.
// Returns a one-hot grant, its index and an any flag for a request vector.
// Assumes IDX_W is wide enough to hold N-1.
module lmb_first #(
    parameter int unsigned N     = 10,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest requester is written last and wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/lmb_entry.sv
// Module: one line-wide combining entry.
// Tracks the line number, a per-byte written mask, and fill and request state.
// Assumes the parent never asserts alloc and merge together, and never sends a
// fill response before the request was taken.
module lmb_entry #(
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned LINE_AW    = 26,
    localparam int unsigned LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  merge,
    input  logic                  req_taken,
    input  logic                  fill,
    input  logic                  drain,
    input  logic [LINE_AW-1:0]    st_line,
    input  logic [LINE_BYTES-1:0] st_mask,
    input  logic [LINE_BITS-1:0]  st_data,
    input  logic [LINE_BITS-1:0]  fill_data,
    output logic                  busy,
    output logic                  need_req,
    output logic                  ready,
    output logic [LINE_AW-1:0]    line,
    output logic [LINE_BITS-1:0]  data
);

    logic                  req_sent;
    logic                  filled;
    logic [LINE_BYTES-1:0] written;

    // Control state: allocate, note request and fill, release on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            req_sent <= 1'b0;
            filled   <= 1'b0;
            written  <= '0;
            line     <= '0;
        end else if (drain) begin
            busy     <= 1'b0;
            req_sent <= 1'b0;
            filled   <= 1'b0;
            written  <= '0;
        end else if (alloc) begin
            busy     <= 1'b1;
            req_sent <= 1'b0;
            filled   <= 1'b0;
            written  <= st_mask;
            line     <= st_line;
        end else begin
            if (req_taken) req_sent <= 1'b1;
            if (fill) begin
                filled  <= 1'b1;
                written <= '1;
            end else if (merge) begin
                written <= written | st_mask;
            end
        end
    end

    // Line bytes: store bytes win, fill only reaches bytes not yet written.
    always_ff @(posedge clk) begin
        if (alloc) begin
            data <= st_data;
        end else begin
            for (int b = 0; b < int'(LINE_BYTES); b++) begin
                if (merge && st_mask[b])
                    data[b*8 +: 8] <= st_data[b*8 +: 8];
                else if (fill && !written[b])
                    data[b*8 +: 8] <= fill_data[b*8 +: 8];
            end
        end
    end

    assign need_req = busy && !req_sent;
    assign ready    = busy && filled;

endmodule

// File: rtl/line_merge_buffer.sv
// Module: line merging store fill buffer (top).
// Cacheable stores merge into line entries and request ownership. Filled lines
// leave as whole-line writes. Uncacheable stores pass through as partial
// writes behind any waiting line.
// Assumes stores are one aligned word (address bits below the word ignored),
// NUM_ENTRIES >= 2, and that fill responses carry tags from earlier requests.
module line_merge_buffer #(
    parameter int unsigned NUM_ENTRIES = 10,
    parameter int unsigned LINE_BYTES  = 64,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned STORE_BYTES = 8,
    parameter int unsigned CNT_W       = 16,
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
    localparam int unsigned WORD_W     = $clog2(STORE_BYTES),
    localparam int unsigned LINE_AW    = ADDR_W - OFF_W,
    localparam int unsigned TAG_W      = $clog2(NUM_ENTRIES),
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8,
    localparam int unsigned ST_BITS    = STORE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [ST_BITS-1:0]    st_data,
    input  logic [STORE_BYTES-1:0] st_be,
    input  logic                  st_uc,
    output logic                  fr_valid,
    input  logic                  fr_ready,
    output logic [LINE_AW-1:0]    fr_line,
    output logic [TAG_W-1:0]      fr_tag,
    input  logic                  fp_valid,
    input  logic [TAG_W-1:0]      fp_tag,
    input  logic [LINE_BITS-1:0]  fp_data,
    output logic                  wo_valid,
    input  logic                  wo_ready,
    output logic                  wo_uc,
    output logic [LINE_AW-1:0]    wo_line,
    output logic [LINE_BITS-1:0]  wo_data,
    output logic [LINE_BYTES-1:0] wo_be,
    output logic [CNT_W-1:0]      full_count
);
    import lmb_pkg::*;

    logic [LINE_AW-1:0]    st_line;
    logic [OFF_W-1:0]      st_off;
    logic [LINE_BYTES-1:0] st_mask;
    logic [LINE_BITS-1:0]  st_ldata;
    logic                  addr_lsb_unused;

    logic [NUM_ENTRIES-1:0] busy_vec, need_vec, rdy_vec, hit_vec, fill_vec;
    logic [NUM_ENTRIES-1:0] free_gnt, req_gnt, rdy_gnt, alloc_vec, merge_vec, drain_vec;
    logic [TAG_W-1:0]       free_idx_unused, rdy_idx_unused;
    logic                   any_free, any_rdy;
    logic [LINE_AW-1:0]     ent_line [NUM_ENTRIES];
    logic [LINE_BITS-1:0]   ent_data [NUM_ENTRIES];

    logic    st_cac, hit_any, hit_blocked, go_hit, go_alloc, full_stall, stall_seen;
    logic    uc_ok;
    wo_src_e wo_src;
    logic [LINE_AW-1:0]   mux_line;
    logic [LINE_BITS-1:0] mux_data;

    // Place the store word at its byte position within the line.
    assign st_line         = st_addr[ADDR_W-1:OFF_W];
    assign st_off          = {st_addr[OFF_W-1:WORD_W], WORD_W'(0)};
    assign st_mask         = LINE_BYTES'(st_be) << st_off;
    assign st_ldata        = LINE_BITS'(st_data) << {st_off, 3'b000};
    assign addr_lsb_unused = ^st_addr[WORD_W-1:0];

    generate
        for (genvar i = 0; i < int'(NUM_ENTRIES); i++) begin : g_ent
            assign hit_vec[i]  = busy_vec[i] && (ent_line[i] == st_line);
            assign fill_vec[i] = fp_valid && (fp_tag == TAG_W'(i));
            lmb_entry #(.LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)) u_ent (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc_vec[i]),
                .merge     (merge_vec[i]),
                .req_taken (req_gnt[i] && fr_ready),
                .fill      (fill_vec[i]),
                .drain     (drain_vec[i]),
                .st_line   (st_line),
                .st_mask   (st_mask),
                .st_data   (st_ldata),
                .fill_data (fp_data),
                .busy      (busy_vec[i]),
                .need_req  (need_vec[i]),
                .ready     (rdy_vec[i]),
                .line      (ent_line[i]),
                .data      (ent_data[i])
            );
        end
    endgenerate

    lmb_first #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_free (
        .req(~busy_vec), .grant(free_gnt), .idx(free_idx_unused), .any(any_free));
    lmb_first #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_req (
        .req(need_vec), .grant(req_gnt), .idx(fr_tag), .any(fr_valid));
    lmb_first #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_rdy (
        .req(rdy_vec), .grant(rdy_gnt), .idx(rdy_idx_unused), .any(any_rdy));

    // Store path decisions: merge on hit, allocate on miss, hold when full.
    assign st_cac      = st_valid && !st_uc;
    assign hit_any     = |hit_vec;
    assign hit_blocked = |(hit_vec & drain_vec);
    assign go_hit      = hit_any && !hit_blocked;
    assign go_alloc    = !hit_any && any_free;
    assign uc_ok       = !any_rdy && wo_ready;
    assign st_ready    = st_uc ? uc_ok : (go_hit || go_alloc);
    assign merge_vec   = (st_cac && go_hit)   ? hit_vec  : '0;
    assign alloc_vec   = (st_cac && go_alloc) ? free_gnt : '0;
    assign full_stall  = st_cac && !hit_any && !any_free;
    assign drain_vec   = wo_ready ? rdy_gnt : '0;

    // Gather line number and data of the selected entries.
    always_comb begin
        mux_line = '0;
        mux_data = '0;
        fr_line  = '0;
        for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
            mux_line = mux_line | ({LINE_AW{rdy_gnt[i]}} & ent_line[i]);
            mux_data = mux_data | ({LINE_BITS{rdy_gnt[i]}} & ent_data[i]);
            fr_line  = fr_line  | ({LINE_AW{req_gnt[i]}} & ent_line[i]);
        end
    end

    // Write-out port: waiting lines first, then an uncacheable store.
    always_comb begin
        wo_src   = any_rdy ? WO_SRC_LINE : WO_SRC_UNCAC;
        wo_valid = any_rdy || (st_valid && st_uc);
        wo_uc    = (wo_src == WO_SRC_UNCAC);
        wo_line  = any_rdy ? mux_line : st_line;
        wo_data  = any_rdy ? mux_data : st_ldata;
        wo_be    = any_rdy ? '1 : st_mask;
    end

    // Full-event counter: one count per held request, not per held cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_count <= '0;
            stall_seen <= 1'b0;
        end else begin
            stall_seen <= full_stall;
            if (full_stall && !stall_seen) full_count <= full_count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lmb_checker.sv
// Module: protocol and ordering checks for line_merge_buffer, bound to the top.
// Assumes the bound signal names of the top module.
module lmb_checker #(
    parameter int unsigned NUM_ENTRIES = 10,
    parameter int unsigned LINE_BYTES  = 64,
    parameter int unsigned CNT_W       = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   st_valid,
    input logic                   st_ready,
    input logic                   st_uc,
    input logic                   fr_valid,
    input logic                   fr_ready,
    input logic                   wo_valid,
    input logic                   wo_ready,
    input logic                   wo_uc,
    input logic [LINE_BYTES-1:0]  wo_be,
    input logic [CNT_W-1:0]       full_count,
    input logic [NUM_ENTRIES-1:0] rdy_vec
);

    AST_FR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fr_valid && !fr_ready |=> fr_valid);                              // R2
    AST_LINE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        wo_valid && !wo_uc |-> &wo_be);                                   // R5
    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wo_valid && !wo_uc && !wo_ready |=> wo_valid && !wo_uc);          // R5
    AST_UC_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_uc && st_ready |-> wo_valid && wo_uc && wo_ready); // R6
    AST_UC_BEHIND_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        wo_valid && wo_uc |-> rdy_vec == '0);                             // R7
    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (full_count == $past(full_count))
                  || (full_count == $past(full_count) + CNT_W'(1)));      // R8
    AST_FULL_ONLY_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && !st_uc && !st_ready) |=> full_count == $past(full_count)); // R8

endmodule

bind line_merge_buffer lmb_checker #(
    .NUM_ENTRIES(NUM_ENTRIES), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_uc(st_uc), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_uc(wo_uc), .wo_be(wo_be),
    .full_count(full_count), .rdy_vec(rdy_vec)
);

// File: tb/line_merge_buffer_tb.sv
`timescale 1ns/1ps
module line_merge_buffer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0, st_uc = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [63:0]  st_data = '0;
    logic [7:0]   st_be = '0;
    logic         fr_valid, fr_ready = 1'b1;
    logic [25:0]  fr_line;
    logic [3:0]   fr_tag;
    logic         fp_valid = 1'b0;
    logic [3:0]   fp_tag = '0;
    logic [511:0] fp_data = '0;
    logic         wo_valid, wo_ready = 1'b0, wo_uc;
    logic [25:0]  wo_line;
    logic [511:0] wo_data;
    logic [63:0]  wo_be;
    logic [15:0]  full_count;

    int n_chk = 0, n_fail = 0;
    int fr_cnt = 0;
    logic [3:0]  last_tag;
    logic [25:0] last_line;
    bit done = 0;
    logic         cap_wo_valid, cap_wo_uc;
    logic [25:0]  cap_wo_line;
    logic [511:0] cap_wo_data;
    logic [63:0]  cap_wo_be;
    logic [7:0]   exp_line [64];
    logic [63:0]  exp_wr;

    always #2 clk = ~clk;

    line_merge_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_uc(st_uc),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_line(fr_line), .fr_tag(fr_tag),
        .fp_valid(fp_valid), .fp_tag(fp_tag), .fp_data(fp_data),
        .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_uc(wo_uc), .wo_line(wo_line),
        .wo_data(wo_data), .wo_be(wo_be), .full_count(full_count));

    // Record fill request handshakes.
    always @(posedge clk) begin
        if (rst_n && fr_valid && fr_ready) begin
            fr_cnt    <= fr_cnt + 1;
            last_tag  <= fr_tag;
            last_line <= fr_line;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one store; acc reports whether it was accepted within max_wait cycles.
    task automatic do_store(input logic [31:0] a, input logic [63:0] d,
                            input logic [7:0] be, input logic uc,
                            input int max_wait, output bit acc);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_uc = uc;
        acc = 0;
        for (int w = 0; w < max_wait; w++) begin
            #1;
            if (st_ready) begin
                acc = 1;
                cap_wo_valid = wo_valid; cap_wo_uc = wo_uc; cap_wo_line = wo_line;
                cap_wo_data = wo_data; cap_wo_be = wo_be;
                break;
            end
            @(negedge clk);
        end
        if (acc) begin
            @(posedge clk);
            @(negedge clk);
        end
        st_valid = 1'b0; st_uc = 1'b0;
    endtask

    function automatic logic [511:0] pattern(input logic [7:0] seed);
        logic [511:0] p;
        for (int k = 0; k < 64; k++) p[k*8 +: 8] = seed ^ 8'(k);
        return p;
    endfunction

    task automatic send_fill(input logic [3:0] tag, input logic [511:0] d);
        @(negedge clk);
        fp_valid = 1'b1; fp_tag = tag; fp_data = d;
        @(negedge clk);
        fp_valid = 1'b0;
    endtask

    localparam int NV = 5;
    localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h1000, 32'h1008, 32'h100C, 32'h1038};
    localparam logic [63:0] V_DATA [NV] = '{64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222,
                                            64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444,
                                            64'h5555_5555_5555_5555};
    localparam logic [7:0]  V_BE   [NV] = '{8'hFF, 8'h0F, 8'hFF, 8'hF0, 8'h81};
    localparam int          V_FR   [NV] = '{1, 1, 1, 1, 1};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit acc;
        logic [511:0] fill_p;
        bit data_ok;
        int base;
        repeat (3) @(negedge clk);
        #1;
        chk(!fr_valid && !wo_valid, "R1", "valids in reset", {fr_valid, wo_valid}, 0);
        chk(full_count == 0, "R1", "count in reset", 64'(full_count), 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: merge stores into one line and model the result.
        exp_wr = '0;
        for (int k = 0; k < 64; k++) exp_line[k] = 8'h00;
        for (int v = 0; v < NV; v++) begin
            do_store(V_ADDR[v], V_DATA[v], V_BE[v], 1'b0, 4, acc);
            chk(acc, "R3", "table store accepted", 64'(acc), 1);
            for (int k = 0; k < 8; k++) begin
                if (V_BE[v][k]) begin
                    exp_line[int'(V_ADDR[v][5:3]) * 8 + k] = V_DATA[v][k*8 +: 8];
                    exp_wr[int'(V_ADDR[v][5:3]) * 8 + k] = 1'b1;
                end
            end
            repeat (2) @(negedge clk);
            chk(fr_cnt == V_FR[v], "R3", "fill requests after merge", 64'(fr_cnt), 64'(V_FR[v]));
        end
        chk(last_tag == 0 && last_line == 26'h40, "R2", "request tag and line",
            {last_tag, 6'd0, last_line}, {4'd0, 6'd0, 26'h40});

        // Fill: unwritten bytes from the response, written bytes keep stores.
        fill_p = pattern(8'hC0);
        for (int k = 0; k < 64; k++) if (!exp_wr[k]) exp_line[k] = fill_p[k*8 +: 8];
        send_fill(4'd0, fill_p);
        #1;
        data_ok = 1;
        for (int k = 0; k < 64; k++) if (wo_data[k*8 +: 8] != exp_line[k]) data_ok = 0;
        chk(data_ok, "R4", "merged line bytes", wo_data[63:0],
            {exp_line[7], exp_line[6], exp_line[5], exp_line[4],
             exp_line[3], exp_line[2], exp_line[1], exp_line[0]});
        chk(data_ok && wo_data[56*8 +: 64] == {exp_line[63], exp_line[62], exp_line[61], exp_line[60],
            exp_line[59], exp_line[58], exp_line[57], exp_line[56]}, "R10", "word 7 placement",
            wo_data[56*8 +: 64], 0);
        chk(wo_valid && !wo_uc && wo_be == '1 && wo_line == 26'h40, "R5", "whole line write-out",
            wo_be, 64'hFFFF_FFFF_FFFF_FFFF);
        wo_ready = 1'b1;
        @(negedge clk); wo_ready = 1'b0; #1;
        chk(!wo_valid, "R5", "released after accept", 64'(wo_valid), 0);
        do_store(32'h1000, 64'h0, 8'h01, 1'b0, 4, acc);
        repeat (2) @(negedge clk);
        chk(fr_cnt == 2 && last_tag == 0, "R5", "entry reused after free", 64'(fr_cnt), 2);
        wo_ready = 1'b1;
        send_fill(4'd0, fill_p);
        repeat (2) @(negedge clk);

        // Uncacheable store passes straight through.
        base = fr_cnt;
        do_store(32'h2010, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 1'b1, 4, acc);
        chk(acc && cap_wo_valid && cap_wo_uc, "R6", "uncacheable on write-out",
            {cap_wo_valid, cap_wo_uc}, 2'b11);
        chk(cap_wo_be == (64'h3C << 16) && cap_wo_line == 26'h80, "R6", "partial enables",
            cap_wo_be, 64'h3C << 16);
        chk(cap_wo_data[128 +: 64] == 64'hDEAD_BEEF_CAFE_F00D, "R10", "uncacheable data slot",
            cap_wo_data[128 +: 64], 64'hDEAD_BEEF_CAFE_F00D);
        repeat (2) @(negedge clk);
        chk(fr_cnt == base, "R6", "no fill request", 64'(fr_cnt), 64'(base));

        // Uncacheable store waits behind a ready line.
        wo_ready = 1'b0;
        do_store(32'h3000, 64'h77, 8'h01, 1'b0, 4, acc);
        repeat (2) @(negedge clk);
        send_fill(last_tag, fill_p);
        @(negedge clk);
        wo_ready = 1'b1; st_valid = 1'b1; st_uc = 1'b1; st_addr = 32'h4000; st_be = 8'h01;
        #1;
        chk(!st_ready && wo_valid && !wo_uc, "R7", "line before uncacheable",
            {st_ready, wo_valid, wo_uc}, 3'b010);
        @(negedge clk); #1;
        chk(st_ready && wo_uc, "R7", "uncacheable after line", {st_ready, wo_uc}, 2'b11);
        @(posedge clk); @(negedge clk);
        st_valid = 1'b0; st_uc = 1'b0; wo_ready = 1'b0;

        // Line-strided stores fill the pool; the next one is held.
        base = 0;
        for (int i = 0; i < 10; i++) begin
            do_store(32'h10000 + 32'(i * 64), 64'(i), 8'hFF, 1'b0, 1, acc);
            if (acc) base++;
        end
        chk(base == 10, "R8", "ten lines accepted", 64'(base), 10);
        repeat (3) @(negedge clk);
        chk(last_tag == 9 && fr_cnt == 13, "R2", "tags in index order",
            {last_tag, 28'(fr_cnt)}, {4'd9, 28'd13});
        do_store(32'h20000, 64'hAB, 8'hFF, 1'b0, 5, acc);
        chk(!acc, "R8", "held when full", 64'(acc), 0);
        chk(full_count == 1, "R8", "one count per held request", 64'(full_count), 1);
        do_store(32'h20000, 64'hAB, 8'hFF, 1'b0, 3, acc);
        chk(full_count == 2, "R8", "second held request counted", 64'(full_count), 2);

        // Freeing one entry lets the held store in.
        wo_ready = 1'b1;
        send_fill(4'd0, fill_p);
        repeat (3) @(negedge clk);
        do_store(32'h20000, 64'hAB, 8'hFF, 1'b0, 4, acc);
        chk(acc && full_count == 2, "R9", "accepted after free", {acc, full_count}, {1'b1, 16'd2});
        repeat (2) @(negedge clk);
        for (int t = 0; t < 10; t++) send_fill(4'(t), fill_p);
        repeat (15) @(negedge clk);
        #1;
        chk(!wo_valid && !fr_valid, "R5", "pool drained", {wo_valid, fr_valid}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule